// File: doc/BRIEF.md
# Processor Supervision Watchdog with Reset Pulse Generator

This block watches a service ("kick") line driven by a processor and pulls an active-low reset line when that line stops moving. Every change of the kick level counts as service, whether it rises or falls. If no change is seen before the current timeout window runs out, the reset output goes low for a fixed pulse width. Then a new window starts.

There are two window lengths. After any reset is released, a long grace window applies, so that boot code has time to start servicing. The first kick change after the release switches the block to a shorter window, which it keeps until the next reset. A build parameter can keep the long window at all times. The block can be disabled through an enable input and through a supply-good flag. When either one is low, the block issues no pulses. When both are high again, the block issues one reset pulse and restarts in the long window. All durations are counted in clock ticks. The kick, enable and supply-good inputs are treated as synchronous to the clock, and the kick line is still passed through two synchronizer stages.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_ni` is low, `cpu_rst_no` is low with no clock needed. After `rst_ni` rises, `cpu_rst_no` stays low and returns high on the (PULSE_TICKS+2)-th rising clock edge.
- R2: Every reset pulse that the block generates keeps `cpu_rst_no` low for exactly PULSE_TICKS clock cycles.
- R3: After each pulse, and after reset release, the window is LONG_TICKS cycles. With a constant kick level, `cpu_rst_no` alternates between LONG_TICKS cycles high and PULSE_TICKS cycles low.
- R4: A kick change is acted on at the third rising clock edge after it is applied. From then on, the window in force is SHORT_TICKS cycles: if nothing else happens, the pulse starts SHORT_TICKS cycles after that edge.
- R5: Rising and falling kick changes both restart the current window from zero.
- R6: Kick changes that are acted on while `cpu_rst_no` is low are discarded. The window that follows the pulse is then a full LONG_TICKS window.
- R7: While `enable_i` or `supply_ok_i` is low, `cpu_rst_no` stays high. In the cycle after both are high again, a PULSE_TICKS-long pulse starts, followed by a LONG_TICKS window.
- R8: With LONG_ONLY=1, a kick change restarts a LONG_TICKS window and never selects the short one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| kick_i | input | 1 | Service line from the processor; either level change counts |
| enable_i | input | 1 | High to activate the watchdog |
| supply_ok_i | input | 1 | High while the supply is good; low disables the watchdog |
| cpu_rst_no | output | 1 | Active-low reset to the processor |

## Verification
The bench builds two instances with PULSE_TICKS=4, LONG_TICKS=20 and SHORT_TICKS=8. One uses the two-window mode and the other uses LONG_ONLY=1. These small values keep whole high/low runs short, so every run length can be predicted exactly from the cycle of each kick change. The short values also allow repeated pulses, several kicks in a row and disable/re-enable sequences within a few hundred cycles. Driving both instances with the same stimulus shows directly how a kick shortens one window and lengthens the other.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Controller state: off (disabled), hold (reset pulse), grace (long window),
  // tight (short window)
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_HOLD  = 2'd1,
    WD_GRACE = 2'd2,
    WD_TIGHT = 2'd3
  } wd_state_e;

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q, sync_d;
  logic         prev_q, prev_d;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[MSB-1:0], kick_i};
    end else begin : g_single
      always_comb sync_d = kick_i;
    end
  endgenerate

  // previous synchronized level, always tracked (edges are consumed even when ignored)
  always_comb prev_d = sync_q[MSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o = sync_q[MSB] ^ prev_q;

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 4,
  parameter int LONG_TICKS  = 20,
  parameter int SHORT_TICKS = 8,
  parameter bit LONG_ONLY   = 1'b0,
  parameter int CNT_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             inc_o,
  output logic             rst_out_no
);

  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] last_tick;
  logic             expire;

  always_comb begin
    case (state_q)
      WD_HOLD:  last_tick = PULSE_LAST;
      WD_TIGHT: last_tick = SHORT_LAST;
      default:  last_tick = LONG_LAST;
    endcase
    expire = (cnt_i == last_tick);
  end

  // Priority: disable, then kick edge, then expiry, then count
  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    case (state_q)
      WD_OFF: begin
        if (active_i) begin
          state_d = WD_HOLD;
          clr_o   = 1'b1;
        end
      end
      WD_HOLD: begin
        if (!active_i) begin
          state_d = WD_OFF;
          clr_o   = 1'b1;
        end else if (expire) begin
          state_d = WD_GRACE;
          clr_o   = 1'b1;
        end else begin
          inc_o   = 1'b1;
        end
      end
      WD_GRACE, WD_TIGHT: begin
        if (!active_i) begin
          state_d = WD_OFF;
          clr_o   = 1'b1;
        end else if (edge_i) begin
          if (LONG_ONLY) state_d = WD_GRACE;
          else           state_d = WD_TIGHT;
          clr_o   = 1'b1;
        end else if (expire) begin
          state_d = WD_HOLD;
          clr_o   = 1'b1;
        end else begin
          inc_o   = 1'b1;
        end
      end
      default: begin
        state_d = WD_HOLD;
        clr_o   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_HOLD;
    end else begin
      state_q <= state_d;
    end
  end

  assign rst_out_no = (state_q != WD_HOLD);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int PULSE_TICKS = 140_000,
  parameter int LONG_TICKS  = 1_000_000,
  parameter int SHORT_TICKS = 70_000,
  parameter bit LONG_ONLY   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic enable_i,
  input  logic supply_ok_i,
  output logic cpu_rst_no
);

  localparam int MAX_A = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int MAX_T = (MAX_A > PULSE_TICKS) ? MAX_A : PULSE_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             active;
  logic             kick_edge;
  logic             cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign active = enable_i & supply_ok_i;

  wdog_kick_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  wdog_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  wdog_ctrl #(
    .PULSE_TICKS (PULSE_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_ONLY   (LONG_ONLY),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .active_i   (active),
    .edge_i     (kick_edge),
    .cnt_i      (cnt),
    .clr_o      (cnt_clr),
    .inc_o      (cnt_inc),
    .rst_out_no (cpu_rst_no)
  );

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int PULSE_TICKS = 4,
  parameter int LONG_TICKS  = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic active_i,
  input logic kick_edge_i,
  input logic cpu_rst_no
);

  int   lo_run;
  int   hi_run;
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= 0;
      hi_run <= 0;
      armed  <= 1'b0;
    end else begin
      armed  <= 1'b1;
      lo_run <= cpu_rst_no ? 0 : lo_run + 1;
      hi_run <= (!cpu_rst_no || !active_i || kick_edge_i) ? 0 : hi_run + 1;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rst_no && !$past(cpu_rst_no)) |-> (lo_run == PULSE_TICKS));

  // R3
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run <= LONG_TICKS);

  // R7
  quiet_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(active_i)) |-> cpu_rst_no);

  // R7
  pulse_needs_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !cpu_rst_no && $past(cpu_rst_no)) |-> $past(active_i));

endmodule

bind wdog_supervisor wdog_supervisor_chk #(
  .PULSE_TICKS (PULSE_TICKS),
  .LONG_TICKS  (LONG_TICKS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_int_n),
  .active_i    (active),
  .kick_edge_i (kick_edge),
  .cpu_rst_no  (cpu_rst_no)
);

// File: tb/sim_wdog_supervisor.sv
`timescale 1ns/1ps
module sim_wdog_supervisor;

  localparam int PULSE = 4;
  localparam int LONG  = 20;
  localparam int SHORT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic en = 1'b1;
  logic sup = 1'b1;
  logic out0, out1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_supervisor #(.PULSE_TICKS(PULSE), .LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .LONG_ONLY(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .enable_i(en), .supply_ok_i(sup), .cpu_rst_no(out0));

  wdog_supervisor #(.PULSE_TICKS(PULSE), .LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .LONG_ONLY(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .enable_i(en), .supply_ok_i(sup), .cpu_rst_no(out1));

  // scoreboard queues: expected (high run, low run) per instance
  int    exp_hi [2][$];
  int    exp_lo [2][$];
  string exp_tag[2][$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int i, input int hi, input int lo, input string tag);
    exp_hi[i].push_back(hi);
    exp_lo[i].push_back(lo);
    exp_tag[i].push_back(tag);
  endtask

  // monitor: measures complete high-then-low runs and compares them
  int hc[2];
  int lc[2];
  bit armed[2];
  bit inlow[2];

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      bit v;
      v = (i == 0) ? out0 : out1;
      if (!rst_n) begin
        armed[i] = 1'b0;
      end else if (!armed[i]) begin
        if (v) begin
          armed[i] = 1'b1; hc[i] = 1; lc[i] = 0; inlow[i] = 1'b0;
        end
      end else if (v) begin
        if (inlow[i]) begin
          if (exp_hi[i].size() == 0) begin
            check(1'b0, "R3 unexpected pulse", hc[i], 0);
          end else begin
            int    eh, el;
            string t;
            eh = exp_hi[i].pop_front();
            el = exp_lo[i].pop_front();
            t  = exp_tag[i].pop_front();
            check(hc[i] == eh, $sformatf("%s high run u%0d", t, i), hc[i], eh);
            check(lc[i] == el, $sformatf("R2 low run u%0d", i), lc[i], el);
          end
          hc[i] = 1; lc[i] = 0; inlow[i] = 1'b0;
        end else begin
          hc[i]++;
        end
      end else begin
        inlow[i] = 1'b1;
        lc[i]++;
      end
    end
  end

  // R1: system reset, async low, then release timing; returns on first high sample
  task automatic sys_reset();
    int lo0, lo1, guard;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out0 == 1'b0, "R1 async low u0", out0, 0);
    check(out1 == 1'b0, "R1 async low u1", out1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lo0 = 0; lo1 = 0; guard = 0;
    forever begin
      @(negedge clk);
      if ((out0 && out1) || guard > 100) break;
      if (!out0) lo0++;
      if (!out1) lo1++;
      guard++;
    end
    check(lo0 == PULSE + 1, "R1 release u0", lo0, PULSE + 1);
    check(lo1 == PULSE + 1, "R1 release u1", lo1, PULSE + 1);
  endtask

  task automatic drain();
    while (exp_hi[0].size() != 0 || exp_hi[1].size() != 0) @(negedge clk);
  endtask

  initial begin
    // R3: idle, repeated pulses
    sys_reset();
    push(0, LONG, PULSE, "R3"); push(0, LONG, PULSE, "R3");
    push(1, LONG, PULSE, "R3"); push(1, LONG, PULSE, "R3");
    drain();

    // R4 / R8: single kick at high sample 5
    sys_reset();
    push(0, 5 + 2 + SHORT, PULSE, "R4"); push(0, LONG, PULSE, "R3");
    push(1, 5 + 2 + LONG, PULSE, "R8");
    repeat (4) @(negedge clk);
    kick = ~kick;
    drain();

    // R5 / R8: rise, fall, rise at samples 5, 10, 15
    sys_reset();
    push(0, 15 + 2 + SHORT, PULSE, "R5"); push(0, LONG, PULSE, "R3");
    push(1, 15 + 2 + LONG, PULSE, "R8");
    repeat (4) @(negedge clk); kick = ~kick;
    repeat (5) @(negedge clk); kick = ~kick;
    repeat (5) @(negedge clk); kick = ~kick;
    drain();

    // R6: kick change during reset pulse is discarded
    sys_reset();
    push(0, LONG, PULSE, "R6"); push(0, LONG, PULSE, "R6");
    push(1, LONG, PULSE, "R6"); push(1, LONG, PULSE, "R6");
    do @(negedge clk); while (out0);
    kick = ~kick;
    drain();

    // R7: enable low then high
    sys_reset();
    push(0, 46, PULSE, "R7"); push(0, LONG, PULSE, "R7");
    push(1, 46, PULSE, "R7"); push(1, LONG, PULSE, "R7");
    repeat (5) @(negedge clk); en = 1'b0;
    repeat (40) @(negedge clk); en = 1'b1;
    drain();

    // R7: supply-good low then high
    sys_reset();
    push(0, 36, PULSE, "R7"); push(0, LONG, PULSE, "R7");
    push(1, 36, PULSE, "R7"); push(1, LONG, PULSE, "R7");
    repeat (5) @(negedge clk); sup = 1'b0;
    repeat (30) @(negedge clk); sup = 1'b1;
    drain();

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule